// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one channel of a programmable interval timer: a 16-bit down-counter that shapes a single output waveform from a count tick, a gate level and a configuration written by a register interface. All logic runs on one system clock. The counting clock arrives as a one-cycle `tick` enable, so every "clock period" of the waveform below means one tick. A configuration write presents a mode, a count format (binary or BCD) and an initial count on parallel inputs together with the `cfg_wr` strobe. A snapshot of the live count can be taken at any time with `latch_req` without disturbing counting.

Six waveform modes exist: terminal-count flag (0), gate-triggered one-shot (1), rate generator (2), square wave (3), software-started strobe (4) and gate-started strobe (5). Mode codes 6 and 7 select modes 2 and 3. An initial count of zero stands for the largest count the format allows. BCD counting borrows across decimal digits.

The control FSM has six states. IDLE is the state after reset: no count, output high. A write moves any state to LOAD (modes 0, 2, 3, 4) or ARM (modes 1, 5). LOAD goes to RUN on the next tick and copies the count. ARM goes to RUN on a tick when a gate rising edge is pending. RUN goes to DONE in mode 0 when the count reaches zero. In mode 1 it goes back to ARM. In modes 4 and 5 it goes to STROBE. In modes 2 and 3 it stays in RUN and reloads the count. STROBE goes on the next enabled tick to DONE (mode 4) or ARM (mode 5), or back to RUN when mode 5 is retriggered. DONE holds until the next write.

Top module: `pit_channel`

## Requirements
- R1: After reset `out` is 1, the counter and `latch_val` are 0. Ticks do nothing until a count is written.
- R2: A write captures mode, format and count. The counter takes the count on the first tick in a later cycle. A tick in the same cycle as the write does not load it.
- R3: In modes 0, 2, 3 and 4 a tick decrements only while `gate` is 1. With `gate` at 0 or no tick, the count holds.
- R4: Mode 0: `out` drops to 0 in the cycle after the write. It rises when the count reaches 0 and stays high until the next write. The count rests at 0.
- R5: Mode 1: `out` stays 1 until a `gate` rising edge. The next tick loads the count and drops `out`. `out` rises when the count reaches 0. A rising edge while counting reloads the count on the next tick.
- R6: Mode 2: `out` is 1 except while the count is 1. A tick at count 1 reloads N, so the period is N ticks (N ≥ 2).
- R7: Mode 3: period N ticks, high for ceil(N/2) ticks and low for floor(N/2) ticks, for even and odd N ≥ 2.
- R8: Mode 4: `out` goes low for one enabled tick when the count reaches 0. It then stays high until another write.
- R9: Mode 5: as mode 4, but counting starts on the tick after a `gate` rising edge, ticks count whatever the gate level, and a new edge restarts it.
- R10: An initial count of 0 counts 65536 ticks in binary and 10000 in BCD.
- R11: Mode codes 6 and 7 behave as modes 2 and 3.
- R12: With `cfg_bcd` = 1 each nibble is a decimal digit (bits 3:0 units). A decrement borrows across digits (0x0100 → 0x0099, 0x0000 → 0x9999).
- R13: `latch_req` copies the count of that cycle into `latch_val` on the next cycle. Otherwise `latch_val` holds, and counting goes on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle count clock enable |
| gate | input | 1 | Gate level, sampled each cycle |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Waveform mode code |
| cfg_bcd | input | 1 | 1 selects BCD counting |
| cfg_count | input | 16 | Initial count |
| latch_req | input | 1 | Snapshot request |
| out | output | 1 | Waveform output |
| latch_val | output | 16 | Count snapshot |

## Verification
The bench drives sparse tick patterns and gate gaps. A counter that ignored `gate` or ran on idle cycles would drift from the reference in R3 runs. It targets odd square-wave counts, where a wrong half point gives a duty off by one tick. It also targets BCD borrow from 0x0100, where a binary decrement would show 0x00FF. Zero counts in both formats would expose a design that stops at once or wraps at the wrong modulus. It retriggers the one-shot and the gate strobe mid-count, and also a write in the same cycle as a tick, which would show an early reload or a lost trigger.

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_ARM,
        S_RUN,
        S_STROBE,
        S_DONE
    } pit_state_t;

    typedef enum logic [2:0] {
        M_TERM    = 3'd0,
        M_ONESHOT = 3'd1,
        M_RATE    = 3'd2,
        M_SQUARE  = 3'd3,
        M_SWSTB   = 3'd4,
        M_HWSTB   = 3'd5
    } pit_mode_t;

    // codes 6 and 7 alias the periodic modes
    function automatic pit_mode_t fold_mode(input logic [2:0] raw);
        case (raw)
            3'd6:    return M_RATE;
            3'd7:    return M_SQUARE;
            default: return pit_mode_t'(raw);
        endcase
    endfunction

    // modes whose counting ignores the gate level and starts on its edge
    function automatic logic edge_started(input pit_mode_t m);
        return (m == M_ONESHOT) || (m == M_HWSTB);
    endfunction

endpackage

// File: rtl/pit_decr.sv
module pit_decr #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    input  logic         bcd,
    output logic [W-1:0] res
);
    localparam int DIG = W / 4;

    logic [DIG-1:0] brw;
    logic [W-1:0]   bcd_res;

    assign brw[0] = 1'b1;

    for (genvar g = 0; g < DIG; g++) begin : g_dig
        logic [3:0] d;
        assign d = val[4*g +: 4];
        assign bcd_res[4*g +: 4] = !brw[g] ? d :
                                   ((d == 4'd0) ? 4'd9 : d - 4'd1);
        if (g < DIG - 1) begin : g_chain
            assign brw[g+1] = brw[g] & (d == 4'd0);
        end
    end

    assign res = bcd ? bcd_res : (val - W'(1));

endmodule

// File: rtl/pit_half.sv
module pit_half #(
    parameter int W = 16
) (
    input  logic [W-1:0] n,
    input  logic         bcd,
    output logic [W-1:0] half
);
    localparam int DIG = W / 4;

    logic         zero;
    logic [W-1:0] bin_half;
    logic [W-1:0] bcd_half;

    assign zero     = (n == '0);
    assign bin_half = zero ? {1'b1, {(W-1){1'b0}}} : (n >> 1);

    // digit-serial halving: (10*c + d)/2 = 5*c + d/2, c = parity of the digit above
    for (genvar g = 0; g < DIG; g++) begin : g_dig
        logic carry;
        if (g == DIG - 1) begin : g_top
            assign carry = 1'b0;
        end else begin : g_low
            assign carry = n[4*(g+1)];
        end
        if (g == DIG - 1) begin : g_ztop
            assign bcd_half[4*g +: 4] = zero ? 4'd5 :
                (carry ? 4'd5 : 4'd0) + {1'b0, n[4*g+1 +: 3]};
        end else begin : g_zlow
            assign bcd_half[4*g +: 4] = zero ? 4'd0 :
                (carry ? 4'd5 : 4'd0) + {1'b0, n[4*g+1 +: 3]};
        end
    end

    assign half = bcd ? bcd_half : bin_half;

endmodule

// File: rtl/pit_fsm.sv
module pit_fsm
    import pit_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         gate,
    input  logic         gate_rise,
    input  logic         cfg_wr,
    input  pit_mode_t    wr_mode,
    input  pit_mode_t    mode,
    input  logic         bcd,
    input  logic [W-1:0] reload,
    input  logic [W-1:0] dec_val,
    input  logic [W-1:0] half,
    output logic [W-1:0] cnt,
    output logic         out
);
    localparam int          DIG = W / 4;
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    pit_state_t   state, state_n;
    logic [W-1:0] cnt_q, cnt_n;
    logic         out_q, out_n;
    logic         pend_q, pend_n;
    logic         free, step, trig;

    assign free = edge_started(mode);
    assign step = tick & (free | gate);
    assign trig = pend_q | gate_rise;

    always_comb begin
        state_n = state;
        cnt_n   = cnt_q;
        out_n   = out_q;
        pend_n  = pend_q;
        if (cfg_wr) begin
            pend_n  = 1'b0;
            out_n   = (wr_mode != M_TERM);
            state_n = edge_started(wr_mode) ? S_ARM : S_LOAD;
        end else begin
            unique case (state)
                S_IDLE: ;
                S_LOAD: begin
                    if (tick) begin
                        cnt_n   = reload;
                        out_n   = (mode != M_TERM);
                        state_n = S_RUN;
                    end
                end
                S_ARM: begin
                    if (tick && trig) begin
                        cnt_n   = reload;
                        out_n   = (mode == M_HWSTB);
                        pend_n  = 1'b0;
                        state_n = S_RUN;
                    end else if (gate_rise) begin
                        pend_n = 1'b1;
                    end
                end
                S_RUN: begin
                    if (step) begin
                        if (free && trig) begin
                            cnt_n  = reload;
                            out_n  = (mode == M_HWSTB);
                            pend_n = 1'b0;
                        end else begin
                            unique case (mode)
                                M_TERM: begin
                                    cnt_n = dec_val;
                                    if (dec_val == '0) begin
                                        out_n   = 1'b1;
                                        state_n = S_DONE;
                                    end
                                end
                                M_ONESHOT: begin
                                    cnt_n = dec_val;
                                    if (dec_val == '0) begin
                                        out_n   = 1'b1;
                                        state_n = S_ARM;
                                    end
                                end
                                M_RATE: begin
                                    if (cnt_q == ONE) begin
                                        cnt_n = reload;
                                        out_n = 1'b1;
                                    end else begin
                                        cnt_n = dec_val;
                                        out_n = (dec_val != ONE);
                                    end
                                end
                                M_SQUARE: begin
                                    if (cnt_q == ONE) begin
                                        cnt_n = reload;
                                        out_n = 1'b1;
                                    end else begin
                                        cnt_n = dec_val;
                                        out_n = (dec_val == '0) || (dec_val > half);
                                    end
                                end
                                M_SWSTB, M_HWSTB: begin
                                    cnt_n = dec_val;
                                    if (dec_val == '0) begin
                                        out_n   = 1'b0;
                                        state_n = S_STROBE;
                                    end
                                end
                                default: ;
                            endcase
                        end
                    end else if (free && gate_rise) begin
                        pend_n = 1'b1;
                    end
                end
                S_STROBE: begin
                    if (step) begin
                        out_n = 1'b1;
                        if (mode == M_HWSTB && trig) begin
                            cnt_n   = reload;
                            pend_n  = 1'b0;
                            state_n = S_RUN;
                        end else begin
                            state_n = (mode == M_HWSTB) ? S_ARM : S_DONE;
                        end
                    end else if (free && gate_rise) begin
                        pend_n = 1'b1;
                    end
                end
                S_DONE: ;
                default: state_n = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            out_q  <= 1'b1;
            pend_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_n;
            out_q  <= out_n;
            pend_q <= pend_n;
        end
    end

    assign cnt = cnt_q;
    assign out = out_q;

    function automatic logic digits_ok(input logic [W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < DIG; i++) begin
            if (v[4*i +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOAD && tick && !cfg_wr) |=> (cnt_q == $past(reload)));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cfg_wr) |=> $stable(cnt_q));

    p_term_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DONE && mode == M_TERM) |-> out_q);

    p_idle_armed_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ARM && mode == M_ONESHOT) |-> out_q);

    p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STROBE && step && !cfg_wr) |=> out_q);

    p_bcd_digits_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bcd && state == S_RUN && digits_ok(reload)) |-> digits_ok(cnt_q));

endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               gate,
    input  logic               cfg_wr,
    input  logic [2:0]         cfg_mode,
    input  logic               cfg_bcd,
    input  logic [COUNT_W-1:0] cfg_count,
    input  logic               latch_req,
    output logic               out,
    output logic [COUNT_W-1:0] latch_val
);
    pit_mode_t          mode_r, wr_mode;
    logic               bcd_r;
    logic [COUNT_W-1:0] reload_r;
    logic [COUNT_W-1:0] cnt_w, dec_w, half_w;
    logic [COUNT_W-1:0] latch_q;
    logic               gate_q, gate_rise;

    assign wr_mode   = fold_mode(cfg_mode);
    assign gate_rise = gate & ~gate_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_r   <= M_TERM;
            bcd_r    <= 1'b0;
            reload_r <= '0;
            gate_q   <= 1'b0;
            latch_q  <= '0;
        end else begin
            gate_q <= gate;
            if (cfg_wr) begin
                mode_r   <= wr_mode;
                bcd_r    <= cfg_bcd;
                reload_r <= cfg_count;
            end
            if (latch_req) latch_q <= cnt_w;
        end
    end

    pit_decr #(.W(COUNT_W)) u_decr (
        .val (cnt_w),
        .bcd (bcd_r),
        .res (dec_w)
    );

    pit_half #(.W(COUNT_W)) u_half (
        .n    (reload_r),
        .bcd  (bcd_r),
        .half (half_w)
    );

    pit_fsm #(.W(COUNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .gate      (gate),
        .gate_rise (gate_rise),
        .cfg_wr    (cfg_wr),
        .wr_mode   (wr_mode),
        .mode      (mode_r),
        .bcd       (bcd_r),
        .reload    (reload_r),
        .dec_val   (dec_w),
        .half      (half_w),
        .cnt       (cnt_w),
        .out       (out)
    );

    assign latch_val = latch_q;

    p_latch_copy_r13: assert property (@(posedge clk) disable iff (!rst_n)
        latch_req |=> (latch_val == $past(cnt_w)));

    p_latch_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_req |=> $stable(latch_val));

endmodule

// File: tb/pit_channel_tb.sv
module pit_channel_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        gate = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_mode = 3'd0;
    logic        cfg_bcd = 1'b0;
    logic [15:0] cfg_count = 16'd0;
    logic        latch_req = 1'b0;
    logic        out;
    logic [15:0] latch_val;

    always #(CLK_P/2) clk = ~clk;

    pit_channel u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .gate      (gate),
        .cfg_wr    (cfg_wr),
        .cfg_mode  (cfg_mode),
        .cfg_bcd   (cfg_bcd),
        .cfg_count (cfg_count),
        .latch_req (latch_req),
        .out       (out),
        .latch_val (latch_val)
    );

    int    vectors = 0;
    int    fails = 0;
    int    cyc = 0;
    int    tick_pat = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // behavioural reference
    int          m_state;   // 0 idle 1 load 2 arm 3 run 4 strobe 5 done
    int          m_mode, m_n;
    bit          m_bcd, m_out, m_pend, m_gq;
    logic [15:0] m_cnt, m_latch;

    function automatic int from_bits(input logic [15:0] b, input bit bcd);
        int r = 0;
        if (!bcd) return int'(b);
        for (int i = 3; i >= 0; i--) r = r * 10 + int'(b[4*i +: 4]);
        return r;
    endfunction

    function automatic logic [15:0] to_bits(input int v, input bit bcd);
        logic [15:0] r;
        int t = v;
        if (!bcd) return v[15:0];
        for (int i = 0; i < 4; i++) begin
            r[4*i +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    always @(posedge clk) begin : mdl
        int  mx, v, nv;
        bit  rise, free, step, pe;
        if (!rst_n) begin
            m_state = 0; m_mode = 0; m_n = 0; m_bcd = 0;
            m_out = 1; m_pend = 0; m_gq = 0; m_cnt = 0; m_latch = 0;
        end else begin
            if (latch_req) m_latch = m_cnt;
            rise = gate && !m_gq;
            nv = -1;
            if (cfg_wr) begin
                m_mode  = (cfg_mode >= 3'd6) ? int'(cfg_mode) - 4 : int'(cfg_mode);
                m_bcd   = cfg_bcd;
                m_n     = from_bits(cfg_count, cfg_bcd);
                m_pend  = 0;
                m_out   = (m_mode != 0);
                m_state = (m_mode == 1 || m_mode == 5) ? 2 : 1;
            end else begin
                mx   = m_bcd ? 10000 : 65536;
                v    = from_bits(m_cnt, m_bcd);
                free = (m_mode == 1 || m_mode == 5);
                step = tick && (free || gate);
                pe   = m_pend || rise;
                case (m_state)
                    1: if (tick) begin
                        nv = m_n; m_out = (m_mode != 0); m_state = 3;
                    end
                    2: if (tick && pe) begin
                        nv = m_n; m_out = (m_mode == 5); m_pend = 0; m_state = 3;
                    end else if (rise) m_pend = 1;
                    3: if (step) begin
                        if (free && pe) begin
                            nv = m_n; m_out = (m_mode == 5); m_pend = 0;
                        end else if (m_mode == 2 || m_mode == 3) begin
                            nv = (v == 1) ? m_n : ((v == 0) ? mx - 1 : v - 1);
                            if (m_mode == 2) m_out = (nv != 1);
                            else m_out = (((nv == 0) ? mx : nv) > (((m_n == 0) ? mx : m_n) / 2));
                        end else begin
                            nv = (v == 0) ? mx - 1 : v - 1;
                            if (nv == 0) begin
                                if (m_mode == 0)      begin m_out = 1; m_state = 5; end
                                else if (m_mode == 1) begin m_out = 1; m_state = 2; end
                                else                  begin m_out = 0; m_state = 4; end
                            end
                        end
                    end else if (free && rise) m_pend = 1;
                    4: if (step) begin
                        m_out = 1;
                        if (m_mode == 5 && pe) begin
                            nv = m_n; m_pend = 0; m_state = 3;
                        end else m_state = (m_mode == 5) ? 2 : 5;
                    end else if (free && rise) m_pend = 1;
                    default: ;
                endcase
            end
            if (nv >= 0) m_cnt = to_bits(nv, m_bcd);
            m_gq = gate;
        end
    end

    // per-cycle compare, then drive tick and snapshot request
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            vectors++;
            if (out !== m_out) begin
                fails++;
                $display("FAIL %s: out=%0b expected %0b (cycle %0d)", cur_req, out, m_out, cyc);
            end
            vectors++;
            if (latch_val !== m_latch) begin
                fails++;
                $display("FAIL R13: latch_val=%h expected %h (cycle %0d)", latch_val, m_latch, cyc);
            end
        end
        case (tick_pat)
            1:       tick <= (cyc % 2 == 0);
            2:       tick <= (cyc % 3 != 0);
            default: tick <= 1'b1;
        endcase
        latch_req <= (cyc % 5 == 0);
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int md, input bit b, input logic [15:0] n);
        @(negedge clk);
        cfg_mode  <= md[2:0];
        cfg_bcd   <= b;
        cfg_count <= n;
        cfg_wr    <= 1'b1;
        @(negedge clk);
        cfg_wr    <= 1'b0;
    endtask

    task automatic set_gate(input bit g);
        @(negedge clk);
        gate <= g;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): cycle=%0d expected end before timeout", cyc);
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        run(4);
        rst_n <= 1'b1;
        @(negedge clk);
        vectors++;
        if (out !== 1'b1 || latch_val !== 16'h0) begin
            fails++;
            $display("FAIL R1: out=%0b latch=%h expected 1 0000", out, latch_val);
        end
        cur_req = "R1";   run(8);

        // R2: write lands with a tick in the same cycle, load waits
        cur_req = "R2";   gate <= 1'b1;
        wr(0, 0, 16'd5);  run(3);
        cur_req = "R4";   run(10);
        wr(0, 0, 16'd3);  run(8);

        // R3: sparse ticks and gate gaps
        cur_req = "R3";   tick_pat = 1;
        wr(0, 0, 16'd6);  run(4);
        set_gate(0);      run(7);
        set_gate(1);      run(14);
        tick_pat = 2;
        wr(4, 0, 16'd4);  run(3);
        set_gate(0);      run(5);
        set_gate(1);      run(12);
        tick_pat = 0;

        cur_req = "R6";
        wr(2, 0, 16'd4);  run(10);
        set_gate(0);      run(3);
        set_gate(1);      run(14);

        cur_req = "R7";
        wr(3, 0, 16'd6);  run(20);
        wr(3, 0, 16'd5);  run(20);
        tick_pat = 2;
        wr(3, 0, 16'd7);  run(25);
        tick_pat = 0;

        cur_req = "R8";
        wr(4, 0, 16'd3);  run(12);
        wr(4, 0, 16'd2);  run(8);

        cur_req = "R5";   gate <= 1'b0;
        wr(1, 0, 16'd4);  run(4);
        set_gate(1);      set_gate(0);  run(2);
        set_gate(1);      set_gate(0);  run(9);
        tick_pat = 1;
        set_gate(1);      set_gate(0);  run(12);
        tick_pat = 0;

        cur_req = "R9";
        wr(5, 0, 16'd3);  run(3);
        set_gate(1);      set_gate(0);  run(8);
        set_gate(1);      set_gate(0);  run(4);
        set_gate(1);      set_gate(0);  run(8);
        gate <= 1'b1;

        cur_req = "R11";
        wr(6, 0, 16'd3);  run(12);
        wr(7, 0, 16'd5);  run(15);

        cur_req = "R12";
        wr(2, 1, 16'h0012); run(30);
        wr(3, 1, 16'h0011); run(30);
        wr(0, 1, 16'h0100); run(106);

        cur_req = "R10";
        wr(0, 1, 16'h0000); run(10004);
        wr(3, 1, 16'h0000); run(10010);
        wr(0, 0, 16'h0000); run(65540);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule